// File: doc/BRIEF.md
# Mixed Page-Size Translation Lookaside Buffer

This block is a small, fully associative translation cache for a three-level virtual memory scheme with a 27-bit virtual page number split into three 9-bit chunks. Every entry holds one mapping. Its level field chooses how many chunks take part in the tag compare, so one entry can map a 4 KB page, a 2 MB page or a 1 GB page.

Several lookup ports work in parallel and combinationally. Each port takes a virtual page number, an address-space ID, a 3-bit access command and a user-mode flag. It returns a hit or miss indication, the physical page number, the stored permission bits, and page-fault and access-fault flags. Those flags come from the stored software permissions, the stored memory attributes and the fault flags stored with the entry.

A single refill port writes one chosen way from a page-walk result. A flush port invalidates either every entry or the non-global entries of one address-space ID. The page walker, the replacement choice and the attribute lookup all sit outside this block.

Top module: `mpt_tlb`

## Requirements
- R1: A valid lookup whose 27-bit page number and ID match a level-2 entry asserts hit. It returns that entry's page number and its permissions on `lk_perm_o`, packed as {attribute[5:0], software[6:0]}. The software bits are D,A,G,U,X,W,R from bit 6 down to bit 0. The attribute bits are D-cacheable, I-cacheable, atomic-allowed, executable, writable, readable from bit 5 down to bit 0.
- R2: Level encoding is 0 = 1 GB, 1 = 2 MB, 2 = 4 KB. Level 0 compares only bits 26:18. Level 1 compares bits 26:9. Level 2 compares all bits. An entry stored with level 3 never hits.
- R3: A hit needs the stored ID to equal the requested ID, except on ports whose bit in `IGNORE_ASID_MASK` is set.
- R4: The returned page number keeps the stored upper bits and takes bits 17:0 (level 0) or bits 8:0 (level 1) from the requested page number. At level 2 the stored page number is returned unchanged.
- R5: A valid lookup with no matching entry asserts miss and drives hit, page number, permissions and both fault flags to zero. A port with `lk_valid_i` low drives all of its outputs to zero.
- R6: On a hit, a stored page-fault flag forces the page fault and a stored access-fault flag forces the access fault, whatever the permission bits say.
- R7: Command bits 1:0 encode read = 00, write = 01 and execute = 10; 11 always page-faults. Bit 2 marks an atomic access (100 load-reserved, 101 store-conditional or AMO). A read needs R, a write or any atomic access needs both W and D, and an execute needs X; otherwise the access page-faults.
- R8: A hit on an entry with A clear page-faults. A user-mode access to an entry with U clear also page-faults.
- R9: An access fault is raised when the attribute matching the access is clear: readable for a read, writable for a write, executable for an execute, atomic-allowed for an atomic access.
- R10: A refill writes only the way it names, and only when its valid bit is set. It takes effect at the next clock edge, and lookups in the same cycle still see the old contents.
- R11: When several ways match, the lowest-numbered way supplies every output.
- R12: A flush with the all bit set clears every entry. Otherwise it clears only the entries whose ID equals the flush ID and whose G bit is clear. A refill in the same cycle as a flush keeps its written way valid.
- R13: After reset every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | NUM_PORTS | Lookup valid per port |
| lk_vpn_i | input | NUM_PORTS*27 | Virtual page number per port |
| lk_asid_i | input | NUM_PORTS*ASID_W | Address-space ID per port |
| lk_cmd_i | input | NUM_PORTS*3 | Access command per port |
| lk_user_i | input | NUM_PORTS | User-mode access per port |
| lk_hit_o | output | NUM_PORTS | Hit |
| lk_miss_o | output | NUM_PORTS | Miss |
| lk_ppn_o | output | NUM_PORTS*PPN_W | Physical page number |
| lk_perm_o | output | NUM_PORTS*13 | Attribute and software permission bits |
| lk_pf_o | output | NUM_PORTS | Page fault |
| lk_af_o | output | NUM_PORTS | Access fault |
| rf_valid_i | input | 1 | Refill valid |
| rf_way_i | input | WAY_W | Way to write |
| rf_vpn_i | input | 27 | Refill virtual page number |
| rf_asid_i | input | ASID_W | Refill ID |
| rf_level_i | input | 2 | Refill page level |
| rf_ppn_i | input | PPN_W | Refill physical page number |
| rf_sw_i | input | 7 | Refill software permissions D,A,G,U,X,W,R |
| rf_attr_i | input | 6 | Refill attribute bits |
| rf_pf_i | input | 1 | Refill page-fault flag |
| rf_af_i | input | 1 | Refill access-fault flag |
| fl_valid_i | input | 1 | Flush request |
| fl_all_i | input | 1 | Flush every entry |
| fl_asid_i | input | ASID_W | ID to flush |

## Verification
The bench builds the block with four ways, two ports, a 16-bit ID and a 24-bit page number. Port 1 is set to ignore the ID. With four ways, a single test can hold one entry of each page size plus one fault-flagged entry at the same time. It can also place a duplicate mapping in a higher way, which exercises the priority, global-flush survival and same-cycle refill-versus-flush ordering. With two ports and only one of them ignoring the ID, the same lookup can be compared with and without the ID check.

// File: rtl/mpt_tlb_pkg.sv
package mpt_tlb_pkg;
  localparam int unsigned CHUNK_W = 9;
  localparam int unsigned NUM_LVL = 3;
  localparam int unsigned VPN_W   = CHUNK_W * NUM_LVL;
  localparam int unsigned OFF_W   = VPN_W - CHUNK_W;
  localparam int unsigned LVL_W   = 2;
  localparam int unsigned CMD_W   = 3;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_FETCH = 2'b10,
    OP_RSVD  = 2'b11
  } op_kind_e;

  typedef struct packed {
    logic d;
    logic a;
    logic g;
    logic u;
    logic x;
    logic w;
    logic r;
  } sw_perm_t;

  typedef struct packed {
    logic dcache;
    logic icache;
    logic atomic;
    logic exec;
    logic wr;
    logic rd;
  } attr_t;

  localparam int unsigned SW_W   = $bits(sw_perm_t);
  localparam int unsigned ATTR_W = $bits(attr_t);
  localparam int unsigned PERM_W = SW_W + ATTR_W;
endpackage

// File: rtl/mpt_tlb_match.sv
module mpt_tlb_match
  import mpt_tlb_pkg::*;
#(
  parameter int unsigned ASID_W      = 16,
  parameter int unsigned PPN_W       = 24,
  parameter bit          IGNORE_ASID = 1'b0
) (
  input  logic              ent_valid_i,
  input  logic [VPN_W-1:0]  ent_vpn_i,
  input  logic [ASID_W-1:0] ent_asid_i,
  input  logic [LVL_W-1:0]  ent_level_i,
  input  logic [PPN_W-1:0]  ent_ppn_i,
  input  logic [VPN_W-1:0]  req_vpn_i,
  input  logic [ASID_W-1:0] req_asid_i,
  output logic              hit_o,
  output logic [PPN_W-1:0]  ppn_o
);
  logic [NUM_LVL-1:0] chunk_eq;
  logic               asid_ok;
  logic               cmp_ok;
  logic               lvl_ok;
  logic [PPN_W-1:0]   keep_mask;
  logic [PPN_W-1:0]   fill;
  int unsigned        low_bits;

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_chunk
    assign chunk_eq[k] = ent_vpn_i[k*CHUNK_W +: CHUNK_W] == req_vpn_i[k*CHUNK_W +: CHUNK_W];
  end

  if (IGNORE_ASID) begin : g_no_asid
    assign asid_ok = 1'b1;
  end else begin : g_asid
    assign asid_ok = ent_asid_i == req_asid_i;
  end

  // level L compares chunks NUM_LVL-1 down to NUM_LVL-1-L
  always_comb begin
    lvl_ok = int'(ent_level_i) < NUM_LVL;
    cmp_ok = 1'b1;
    for (int k = 0; k < NUM_LVL; k++) begin
      if (k >= int'(NUM_LVL) - 1 - int'(ent_level_i)) cmp_ok = cmp_ok & chunk_eq[k];
    end
  end

  assign hit_o = ent_valid_i && asid_ok && lvl_ok && cmp_ok;

  always_comb begin
    low_bits = 0;
    if (lvl_ok) low_bits = CHUNK_W * (NUM_LVL - 1 - int'(ent_level_i));
    keep_mask = {PPN_W{1'b1}} << low_bits;
    fill      = PPN_W'(req_vpn_i[OFF_W-1:0]);
    ppn_o     = (ent_ppn_i & keep_mask) | (fill & ~keep_mask);
  end
endmodule

// File: rtl/mpt_tlb_perm.sv
module mpt_tlb_perm
  import mpt_tlb_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             user_i,
  input  sw_perm_t         sw_i,
  input  attr_t            attr_i,
  input  logic             st_pf_i,
  input  logic             st_af_i,
  output logic             pf_o,
  output logic             af_o
);
  op_kind_e kind;
  logic     is_atom;
  logic     rd_op, wr_op, ex_op, bad_op;
  logic     perm_pf, attr_af;

  assign kind    = op_kind_e'(cmd_i[1:0]);
  assign is_atom = cmd_i[CMD_W-1];

  always_comb begin
    rd_op  = 1'b0;
    wr_op  = 1'b0;
    ex_op  = 1'b0;
    bad_op = 1'b0;
    if (is_atom) begin
      wr_op = 1'b0;
    end else begin
      unique case (kind)
        OP_LOAD:  rd_op  = 1'b1;
        OP_STORE: wr_op  = 1'b1;
        OP_FETCH: ex_op  = 1'b1;
        default:  bad_op = 1'b1;
      endcase
    end
  end

  always_comb begin
    perm_pf = bad_op
            | (rd_op & ~sw_i.r)
            | ((wr_op | is_atom) & ~(sw_i.w & sw_i.d))
            | (ex_op & ~sw_i.x)
            | ~sw_i.a
            | (user_i & ~sw_i.u);
    attr_af = (rd_op & ~attr_i.rd)
            | (wr_op & ~attr_i.wr)
            | (ex_op & ~attr_i.exec)
            | (is_atom & ~attr_i.atomic);
  end

  assign pf_o = st_pf_i | perm_pf;
  assign af_o = st_af_i | attr_af;
endmodule

// File: rtl/mpt_tlb_store.sv
module mpt_tlb_store
  import mpt_tlb_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 8,
  parameter int unsigned ASID_W   = 16,
  parameter int unsigned PPN_W    = 24,
  localparam int unsigned WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rf_valid_i,
  input  logic [WAY_W-1:0]  rf_way_i,
  input  logic [VPN_W-1:0]  rf_vpn_i,
  input  logic [ASID_W-1:0] rf_asid_i,
  input  logic [LVL_W-1:0]  rf_level_i,
  input  logic [PPN_W-1:0]  rf_ppn_i,
  input  sw_perm_t          rf_sw_i,
  input  attr_t             rf_attr_i,
  input  logic              rf_pf_i,
  input  logic              rf_af_i,
  input  logic              fl_valid_i,
  input  logic              fl_all_i,
  input  logic [ASID_W-1:0] fl_asid_i,
  output logic [NUM_WAYS-1:0] valid_o,
  output logic [VPN_W-1:0]  vpn_o   [NUM_WAYS],
  output logic [ASID_W-1:0] asid_o  [NUM_WAYS],
  output logic [LVL_W-1:0]  level_o [NUM_WAYS],
  output logic [PPN_W-1:0]  ppn_o   [NUM_WAYS],
  output sw_perm_t          sw_o    [NUM_WAYS],
  output attr_t             attr_o  [NUM_WAYS],
  output logic [NUM_WAYS-1:0] pf_o,
  output logic [NUM_WAYS-1:0] af_o
);
  logic [NUM_WAYS-1:0] valid_q;
  logic [NUM_WAYS-1:0] wr_sel;
  logic [NUM_WAYS-1:0] fl_sel;
  logic [VPN_W-1:0]    vpn_q   [NUM_WAYS];
  logic [ASID_W-1:0]   asid_q  [NUM_WAYS];
  logic [LVL_W-1:0]    level_q [NUM_WAYS];
  logic [PPN_W-1:0]    ppn_q   [NUM_WAYS];
  sw_perm_t            sw_q    [NUM_WAYS];
  attr_t               attr_q  [NUM_WAYS];
  logic [NUM_WAYS-1:0] pf_q;
  logic [NUM_WAYS-1:0] af_q;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_sel
    assign wr_sel[w] = rf_valid_i && (rf_way_i == WAY_W'(w));
    assign fl_sel[w] = fl_valid_i && (fl_all_i || (asid_q[w] == fl_asid_i && !sw_q[w].g));
  end

  // refill wins over a same-cycle flush on its own way
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (wr_sel[w])      valid_q[w] <= 1'b1;
        else if (fl_sel[w]) valid_q[w] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (wr_sel[w]) begin
        vpn_q[w]   <= rf_vpn_i;
        asid_q[w]  <= rf_asid_i;
        level_q[w] <= rf_level_i;
        ppn_q[w]   <= rf_ppn_i;
        sw_q[w]    <= rf_sw_i;
        attr_q[w]  <= rf_attr_i;
        pf_q[w]    <= rf_pf_i;
        af_q[w]    <= rf_af_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign vpn_o   = vpn_q;
  assign asid_o  = asid_q;
  assign level_o = level_q;
  assign ppn_o   = ppn_q;
  assign sw_o    = sw_q;
  assign attr_o  = attr_q;
  assign pf_o    = pf_q;
  assign af_o    = af_q;

  p_refill_lands_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_valid_i && int'(rf_way_i) < NUM_WAYS) |=>
      (valid_q[$past(rf_way_i)] && vpn_q[$past(rf_way_i)] == $past(rf_vpn_i)));

  p_flush_all_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_valid_i && fl_all_i && !rf_valid_i) |=> (valid_q == '0));

  p_no_stray_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rf_valid_i) |=> ((valid_q & ~$past(valid_q)) == '0));
endmodule

// File: rtl/mpt_tlb_port.sv
module mpt_tlb_port
  import mpt_tlb_pkg::*;
#(
  parameter int unsigned NUM_WAYS    = 8,
  parameter int unsigned ASID_W      = 16,
  parameter int unsigned PPN_W       = 24,
  parameter bit          IGNORE_ASID = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lk_valid_i,
  input  logic [VPN_W-1:0]    lk_vpn_i,
  input  logic [ASID_W-1:0]   lk_asid_i,
  input  logic [CMD_W-1:0]    lk_cmd_i,
  input  logic                lk_user_i,
  input  logic [NUM_WAYS-1:0] ent_valid_i,
  input  logic [VPN_W-1:0]    ent_vpn_i   [NUM_WAYS],
  input  logic [ASID_W-1:0]   ent_asid_i  [NUM_WAYS],
  input  logic [LVL_W-1:0]    ent_level_i [NUM_WAYS],
  input  logic [PPN_W-1:0]    ent_ppn_i   [NUM_WAYS],
  input  sw_perm_t            ent_sw_i    [NUM_WAYS],
  input  attr_t               ent_attr_i  [NUM_WAYS],
  input  logic [NUM_WAYS-1:0] ent_pf_i,
  input  logic [NUM_WAYS-1:0] ent_af_i,
  output logic                hit_o,
  output logic                miss_o,
  output logic [PPN_W-1:0]    ppn_o,
  output logic [PERM_W-1:0]   perm_o,
  output logic                pf_o,
  output logic                af_o
);
  logic [NUM_WAYS-1:0] hit_vec;
  logic [NUM_WAYS-1:0] sel;
  logic [PPN_W-1:0]    way_ppn [NUM_WAYS];
  logic [PPN_W-1:0]    sel_ppn;
  logic [SW_W-1:0]     sel_sw;
  logic [ATTR_W-1:0]   sel_attr;
  logic                sel_pf, sel_af;
  logic                any_hit;
  logic                chk_pf, chk_af;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    mpt_tlb_match #(
      .ASID_W     (ASID_W),
      .PPN_W      (PPN_W),
      .IGNORE_ASID(IGNORE_ASID)
    ) u_match (
      .ent_valid_i(ent_valid_i[w]),
      .ent_vpn_i  (ent_vpn_i[w]),
      .ent_asid_i (ent_asid_i[w]),
      .ent_level_i(ent_level_i[w]),
      .ent_ppn_i  (ent_ppn_i[w]),
      .req_vpn_i  (lk_vpn_i),
      .req_asid_i (lk_asid_i),
      .hit_o      (hit_vec[w]),
      .ppn_o      (way_ppn[w])
    );
  end

  // lowest way wins
  always_comb begin
    sel = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) sel = NUM_WAYS'(1) << w;
    end
  end

  always_comb begin
    sel_ppn  = '0;
    sel_sw   = '0;
    sel_attr = '0;
    sel_pf   = 1'b0;
    sel_af   = 1'b0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      sel_ppn  = sel_ppn  | ({PPN_W{sel[w]}}  & way_ppn[w]);
      sel_sw   = sel_sw   | ({SW_W{sel[w]}}   & ent_sw_i[w]);
      sel_attr = sel_attr | ({ATTR_W{sel[w]}} & ent_attr_i[w]);
      sel_pf   = sel_pf   | (sel[w] & ent_pf_i[w]);
      sel_af   = sel_af   | (sel[w] & ent_af_i[w]);
    end
  end

  mpt_tlb_perm u_perm (
    .cmd_i  (lk_cmd_i),
    .user_i (lk_user_i),
    .sw_i   (sw_perm_t'(sel_sw)),
    .attr_i (attr_t'(sel_attr)),
    .st_pf_i(sel_pf),
    .st_af_i(sel_af),
    .pf_o   (chk_pf),
    .af_o   (chk_af)
  );

  assign any_hit = lk_valid_i && (|hit_vec);
  assign hit_o   = any_hit;
  assign miss_o  = lk_valid_i && !(|hit_vec);
  assign ppn_o   = any_hit ? sel_ppn : '0;
  assign perm_o  = any_hit ? {sel_attr, sel_sw} : '0;
  assign pf_o    = any_hit & chk_pf;
  assign af_o    = any_hit & chk_af;

  p_sel_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));

  p_way0_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_vec[0] |-> sel[0]);

  p_miss_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (!hit_o && ppn_o == '0 && perm_o == '0 && !pf_o && !af_o));

  p_stored_pf_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && sel_pf) |-> pf_o);

  p_stored_af_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && sel_af) |-> af_o);
endmodule

// File: rtl/mpt_tlb.sv
module mpt_tlb
  import mpt_tlb_pkg::*;
#(
  parameter int unsigned NUM_WAYS  = 8,
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned ASID_W    = 16,
  parameter int unsigned PPN_W     = 24,
  parameter logic [NUM_PORTS-1:0] IGNORE_ASID_MASK = '0,
  localparam int unsigned WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_PORTS-1:0]          lk_valid_i,
  input  logic [NUM_PORTS*VPN_W-1:0]    lk_vpn_i,
  input  logic [NUM_PORTS*ASID_W-1:0]   lk_asid_i,
  input  logic [NUM_PORTS*CMD_W-1:0]    lk_cmd_i,
  input  logic [NUM_PORTS-1:0]          lk_user_i,
  output logic [NUM_PORTS-1:0]          lk_hit_o,
  output logic [NUM_PORTS-1:0]          lk_miss_o,
  output logic [NUM_PORTS*PPN_W-1:0]    lk_ppn_o,
  output logic [NUM_PORTS*PERM_W-1:0]   lk_perm_o,
  output logic [NUM_PORTS-1:0]          lk_pf_o,
  output logic [NUM_PORTS-1:0]          lk_af_o,
  input  logic                          rf_valid_i,
  input  logic [WAY_W-1:0]              rf_way_i,
  input  logic [VPN_W-1:0]              rf_vpn_i,
  input  logic [ASID_W-1:0]             rf_asid_i,
  input  logic [LVL_W-1:0]              rf_level_i,
  input  logic [PPN_W-1:0]              rf_ppn_i,
  input  logic [SW_W-1:0]               rf_sw_i,
  input  logic [ATTR_W-1:0]             rf_attr_i,
  input  logic                          rf_pf_i,
  input  logic                          rf_af_i,
  input  logic                          fl_valid_i,
  input  logic                          fl_all_i,
  input  logic [ASID_W-1:0]             fl_asid_i
);
  logic [NUM_WAYS-1:0] ent_valid;
  logic [VPN_W-1:0]    ent_vpn   [NUM_WAYS];
  logic [ASID_W-1:0]   ent_asid  [NUM_WAYS];
  logic [LVL_W-1:0]    ent_level [NUM_WAYS];
  logic [PPN_W-1:0]    ent_ppn   [NUM_WAYS];
  sw_perm_t            ent_sw    [NUM_WAYS];
  attr_t               ent_attr  [NUM_WAYS];
  logic [NUM_WAYS-1:0] ent_pf;
  logic [NUM_WAYS-1:0] ent_af;

  mpt_tlb_store #(
    .NUM_WAYS(NUM_WAYS),
    .ASID_W  (ASID_W),
    .PPN_W   (PPN_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rf_valid_i(rf_valid_i),
    .rf_way_i  (rf_way_i),
    .rf_vpn_i  (rf_vpn_i),
    .rf_asid_i (rf_asid_i),
    .rf_level_i(rf_level_i),
    .rf_ppn_i  (rf_ppn_i),
    .rf_sw_i   (sw_perm_t'(rf_sw_i)),
    .rf_attr_i (attr_t'(rf_attr_i)),
    .rf_pf_i   (rf_pf_i),
    .rf_af_i   (rf_af_i),
    .fl_valid_i(fl_valid_i),
    .fl_all_i  (fl_all_i),
    .fl_asid_i (fl_asid_i),
    .valid_o   (ent_valid),
    .vpn_o     (ent_vpn),
    .asid_o    (ent_asid),
    .level_o   (ent_level),
    .ppn_o     (ent_ppn),
    .sw_o      (ent_sw),
    .attr_o    (ent_attr),
    .pf_o      (ent_pf),
    .af_o      (ent_af)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    mpt_tlb_port #(
      .NUM_WAYS   (NUM_WAYS),
      .ASID_W     (ASID_W),
      .PPN_W      (PPN_W),
      .IGNORE_ASID(IGNORE_ASID_MASK[p])
    ) u_port (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lk_valid_i (lk_valid_i[p]),
      .lk_vpn_i   (lk_vpn_i[p*VPN_W +: VPN_W]),
      .lk_asid_i  (lk_asid_i[p*ASID_W +: ASID_W]),
      .lk_cmd_i   (lk_cmd_i[p*CMD_W +: CMD_W]),
      .lk_user_i  (lk_user_i[p]),
      .ent_valid_i(ent_valid),
      .ent_vpn_i  (ent_vpn),
      .ent_asid_i (ent_asid),
      .ent_level_i(ent_level),
      .ent_ppn_i  (ent_ppn),
      .ent_sw_i   (ent_sw),
      .ent_attr_i (ent_attr),
      .ent_pf_i   (ent_pf),
      .ent_af_i   (ent_af),
      .hit_o      (lk_hit_o[p]),
      .miss_o     (lk_miss_o[p]),
      .ppn_o      (lk_ppn_o[p*PPN_W +: PPN_W]),
      .perm_o     (lk_perm_o[p*PERM_W +: PERM_W]),
      .pf_o       (lk_pf_o[p]),
      .af_o       (lk_af_o[p])
    );
  end
endmodule

// File: tb/mpt_tlb_test.sv
module mpt_tlb_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int NP = 2;
  localparam int AW = 16;
  localparam int PW = 24;
  localparam int VW = 27;
  localparam int NV = 16;

  typedef struct packed {
    logic        port;
    logic [26:0] vpn;
    logic [15:0] asid;
    logic [2:0]  cmd;
    logic        user;
    logic        hit;
    logic [23:0] ppn;
    logic        pf;
    logic        af;
    logic [7:0]  req;
  } vec_t;

  // port, vpn, asid, cmd, user, hit, ppn, pf, af, requirement
  localparam vec_t VECS [NV] = '{
    '{1'b0, 27'h1234567, 16'd5, 3'b000, 1'b1, 1'b1, 24'hABCDEF, 1'b0, 1'b0, 8'd1},  // R1
    '{1'b0, 27'h1234567, 16'd6, 3'b000, 1'b1, 1'b0, 24'h000000, 1'b0, 1'b0, 8'd3},  // R3
    '{1'b1, 27'h1234567, 16'd6, 3'b000, 1'b1, 1'b1, 24'hABCDEF, 1'b0, 1'b0, 8'd3},  // R3 ignore
    '{1'b0, 27'h1234566, 16'd5, 3'b000, 1'b1, 1'b0, 24'h000000, 1'b0, 1'b0, 8'd2},  // R2
    '{1'b0, 27'h15555F3, 16'd5, 3'b010, 1'b0, 1'b1, 24'h7655F3, 1'b0, 1'b0, 8'd4},  // R4 2M
    '{1'b0, 27'h15555F3, 16'd5, 3'b000, 1'b0, 1'b1, 24'h7655F3, 1'b1, 1'b1, 8'd7},  // R7 R9
    '{1'b0, 27'h1555600, 16'd5, 3'b010, 1'b0, 1'b0, 24'h000000, 1'b0, 1'b0, 8'd2},  // R2 mid chunk
    '{1'b0, 27'h7FE4645, 16'd7, 3'b000, 1'b0, 1'b1, 24'hC64645, 1'b0, 1'b0, 8'd4},  // R4 1G
    '{1'b0, 27'h7FE4645, 16'd5, 3'b000, 1'b0, 1'b0, 24'h000000, 1'b0, 1'b0, 8'd3},  // R3
    '{1'b0, 27'h7FE4645, 16'd7, 3'b001, 1'b0, 1'b1, 24'hC64645, 1'b0, 1'b1, 8'd9},  // R9
    '{1'b0, 27'h7FE4645, 16'd7, 3'b000, 1'b1, 1'b1, 24'hC64645, 1'b1, 1'b0, 8'd8},  // R8 user
    '{1'b0, 27'h0000ABC, 16'd5, 3'b000, 1'b0, 1'b1, 24'h000111, 1'b1, 1'b0, 8'd6},  // R6
    '{1'b0, 27'h1234567, 16'd5, 3'b001, 1'b1, 1'b1, 24'hABCDEF, 1'b0, 1'b0, 8'd7},  // R7 write
    '{1'b0, 27'h1234567, 16'd5, 3'b101, 1'b1, 1'b1, 24'hABCDEF, 1'b0, 1'b0, 8'd7},  // R7 amo
    '{1'b0, 27'h15555F3, 16'd5, 3'b100, 1'b0, 1'b1, 24'h7655F3, 1'b1, 1'b1, 8'd7},  // R7 R9 lr
    '{1'b0, 27'h1234567, 16'd5, 3'b011, 1'b1, 1'b1, 24'hABCDEF, 1'b1, 1'b0, 8'd7}   // R7 reserved
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     lk_valid = '0;
  logic [NP*VW-1:0]  lk_vpn = '0;
  logic [NP*AW-1:0]  lk_asid = '0;
  logic [NP*3-1:0]   lk_cmd = '0;
  logic [NP-1:0]     lk_user = '0;
  logic [NP-1:0]     lk_hit, lk_miss, lk_pf, lk_af;
  logic [NP*PW-1:0]  lk_ppn;
  logic [NP*13-1:0]  lk_perm;
  logic              rf_valid = 1'b0;
  logic [1:0]        rf_way = '0;
  logic [VW-1:0]     rf_vpn = '0;
  logic [AW-1:0]     rf_asid = '0;
  logic [1:0]        rf_level = '0;
  logic [PW-1:0]     rf_ppn = '0;
  logic [6:0]        rf_sw = '0;
  logic [5:0]        rf_attr = '0;
  logic              rf_pf = 1'b0, rf_af = 1'b0;
  logic              fl_valid = 1'b0, fl_all = 1'b0;
  logic [AW-1:0]     fl_asid = '0;
  int                n_chk = 0;
  int                n_err = 0;
  bit                done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpt_tlb #(
    .NUM_WAYS(NW), .NUM_PORTS(NP), .ASID_W(AW), .PPN_W(PW), .IGNORE_ASID_MASK(2'b10)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_vpn_i(lk_vpn), .lk_asid_i(lk_asid), .lk_cmd_i(lk_cmd),
    .lk_user_i(lk_user), .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_ppn_o(lk_ppn),
    .lk_perm_o(lk_perm), .lk_pf_o(lk_pf), .lk_af_o(lk_af),
    .rf_valid_i(rf_valid), .rf_way_i(rf_way), .rf_vpn_i(rf_vpn), .rf_asid_i(rf_asid),
    .rf_level_i(rf_level), .rf_ppn_i(rf_ppn), .rf_sw_i(rf_sw), .rf_attr_i(rf_attr),
    .rf_pf_i(rf_pf), .rf_af_i(rf_af),
    .fl_valid_i(fl_valid), .fl_all_i(fl_all), .fl_asid_i(fl_asid)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic look(input int p, input logic [26:0] vpn, input logic [15:0] asid,
                      input logic [2:0] cmd, input logic user);
    lk_valid = '0;
    lk_valid[p] = 1'b1;
    lk_vpn[p*VW +: VW] = vpn;
    lk_asid[p*AW +: AW] = asid;
    lk_cmd[p*3 +: 3] = cmd;
    lk_user[p] = user;
    #1;
  endtask

  task automatic expect_res(input string tag, input int p, input logic hit,
                            input logic [23:0] ppn, input logic pf, input logic af);
    check({tag, " hit"},  64'(lk_hit[p]), 64'(hit));
    check({tag, " miss"}, 64'(lk_miss[p]), 64'(!hit));
    check({tag, " ppn"},  64'(lk_ppn[p*PW +: PW]), 64'(ppn));
    check({tag, " pf"},   64'(lk_pf[p]), 64'(pf));
    check({tag, " af"},   64'(lk_af[p]), 64'(af));
  endtask

  task automatic refill(input int way, input logic [26:0] vpn, input logic [15:0] asid,
                        input logic [1:0] lvl, input logic [23:0] ppn, input logic [6:0] sw,
                        input logic [5:0] attr, input logic pf, input logic af);
    @(negedge clk);
    rf_valid = 1'b1; rf_way = 2'(way); rf_vpn = vpn; rf_asid = asid; rf_level = lvl;
    rf_ppn = ppn; rf_sw = sw; rf_attr = attr; rf_pf = pf; rf_af = af;
    @(negedge clk);
    rf_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13: empty after reset
    look(0, 27'h1234567, 16'd5, 3'b000, 1'b1);
    expect_res("R13 reset", 0, 1'b0, 24'h0, 1'b0, 1'b0);
    // R5: idle port drives zero
    lk_valid = '0; #1;
    check("R5 idle hit", 64'(lk_hit), 64'd0);
    check("R5 idle miss", 64'(lk_miss), 64'd0);

    refill(0, 27'h1234567, 16'd5, 2'd2, 24'hABCDEF, 7'b1101011, 6'h3F, 1'b0, 1'b0);
    refill(1, 27'h1555400, 16'd5, 2'd1, 24'h765432, 7'b0100100, 6'b000100, 1'b0, 1'b0);
    refill(2, 27'h7FC0000, 16'd7, 2'd0, 24'hC50000, 7'b1110011, 6'b000001, 1'b0, 1'b0);
    refill(3, 27'h0000ABC, 16'd5, 2'd2, 24'h000111, 7'b1111111, 6'h3F, 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      look(int'(VECS[i].port), VECS[i].vpn, VECS[i].asid, VECS[i].cmd, VECS[i].user);
      expect_res($sformatf("R%0d vec%0d", VECS[i].req, i), int'(VECS[i].port),
                 VECS[i].hit, VECS[i].ppn, VECS[i].pf, VECS[i].af);
    end

    // R1: permission output {attr, sw}
    look(0, 27'h1234567, 16'd5, 3'b000, 1'b1);
    check("R1 perm", 64'(lk_perm[12:0]), 64'h1FEB);

    // R10: no same-cycle bypass, refill replaces only way 3
    @(negedge clk);
    rf_valid = 1'b1; rf_way = 2'd3; rf_vpn = 27'h1234567; rf_asid = 16'd5; rf_level = 2'd2;
    rf_ppn = 24'h000222; rf_sw = 7'b1111011; rf_attr = 6'h3F; rf_pf = 1'b0; rf_af = 1'b0;
    look(0, 27'h0000ABC, 16'd5, 3'b000, 1'b0);
    expect_res("R10 bypass", 0, 1'b1, 24'h000111, 1'b1, 1'b0);
    @(negedge clk);
    rf_valid = 1'b0;
    look(0, 27'h0000ABC, 16'd5, 3'b000, 1'b0);
    expect_res("R10 replaced", 0, 1'b0, 24'h0, 1'b0, 1'b0);
    look(0, 27'h7FE4645, 16'd7, 3'b000, 1'b0);
    expect_res("R10 other way kept", 0, 1'b1, 24'hC64645, 1'b0, 1'b0);
    // R11: ways 0 and 3 both match
    look(0, 27'h1234567, 16'd5, 3'b000, 1'b1);
    expect_res("R11 lowest way", 0, 1'b1, 24'hABCDEF, 1'b0, 1'b0);

    // R12: flush by ID keeps global entries
    @(negedge clk);
    fl_valid = 1'b1; fl_all = 1'b0; fl_asid = 16'd5;
    @(negedge clk);
    fl_valid = 1'b0;
    look(0, 27'h1234567, 16'd5, 3'b000, 1'b1);
    expect_res("R12 global kept", 0, 1'b1, 24'h000222, 1'b0, 1'b0);
    look(0, 27'h15555F3, 16'd5, 3'b010, 1'b0);
    expect_res("R12 id flushed", 0, 1'b0, 24'h0, 1'b0, 1'b0);
    look(0, 27'h7FE4645, 16'd7, 3'b000, 1'b0);
    expect_res("R12 other id kept", 0, 1'b1, 24'hC64645, 1'b0, 1'b0);

    // R8: A clear
    refill(0, 27'h0000100, 16'd5, 2'd2, 24'h000333, 7'b1001011, 6'h3F, 1'b0, 1'b0);
    look(0, 27'h0000100, 16'd5, 3'b000, 1'b1);
    expect_res("R8 a clear", 0, 1'b1, 24'h000333, 1'b1, 1'b0);
    // R2: level 3 never hits
    refill(1, 27'h0000200, 16'd5, 2'd3, 24'h000999, 7'b1101011, 6'h3F, 1'b0, 1'b0);
    look(0, 27'h0000200, 16'd5, 3'b000, 1'b1);
    expect_res("R2 level3", 0, 1'b0, 24'h0, 1'b0, 1'b0);

    // R12: flush all with same-cycle refill
    @(negedge clk);
    fl_valid = 1'b1; fl_all = 1'b1;
    rf_valid = 1'b1; rf_way = 2'd1; rf_vpn = 27'h0000300; rf_asid = 16'd5; rf_level = 2'd2;
    rf_ppn = 24'h000444; rf_sw = 7'b1101011; rf_attr = 6'h3F; rf_pf = 1'b0; rf_af = 1'b0;
    @(negedge clk);
    fl_valid = 1'b0; fl_all = 1'b0; rf_valid = 1'b0;
    look(0, 27'h0000300, 16'd5, 3'b000, 1'b1);
    expect_res("R12 refill wins", 0, 1'b1, 24'h000444, 1'b0, 1'b0);
    look(0, 27'h1234567, 16'd5, 3'b000, 1'b1);
    expect_res("R12 flush all", 0, 1'b0, 24'h0, 1'b0, 1'b0);
    look(1, 27'h7FE4645, 16'd7, 3'b000, 1'b0);
    expect_res("R12 flush all global", 1, 1'b0, 24'h0, 1'b0, 1'b0);

    // R10: refill without valid is ignored
    @(negedge clk);
    rf_valid = 1'b0; rf_way = 2'd0; rf_vpn = 27'h0000500; rf_ppn = 24'h000555;
    @(negedge clk);
    look(0, 27'h0000500, 16'd5, 3'b000, 1'b1);
    expect_res("R10 no valid", 0, 1'b0, 24'h0, 1'b0, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule